// File: doc/BRIEF.md
# Pin Direction Controller with Safety Abort

This block owns a bank of general-purpose pins. Software sets each pin's direction and its drive level through a small write-only register port. The current settings and the synchronized pin levels are always visible on plain readback outputs. A safety abort input overrides the direction setting. While abort is held, no pin is driven, so board resistors alone decide the pin levels.

The stored direction is kept while the abort is active. It comes back by itself when the abort drops, and no software write is needed. Direction writes may arrive during an abort. They update the stored setting at once, but no driver is enabled until the abort has ended. This holds even when the write and the abort change in the same cycle.

The output-enable vector comes only from flops: the stored direction bits and a registered copy of the abort input. This leaves no combinational path from the abort or write inputs to the pad enables. All ports are control or status signals, so none of them uses a valid/ready handshake.

Top module: `gpio_safe_dir`

## Requirements
- R1: After reset every output enable is 0 (all pins high impedance, no pull), and the direction and output-data registers read back as 0.
- R2: A write with `wr_addr_i` = 0 loads the direction register. A 1 in a bit makes that pin an output. When abort is low, `pin_oe_o` equals the new value from the first clock edge that samples the write.
- R3: A write with `wr_addr_i` = 1 loads the output-data register. `pin_out_o` and `dout_rd_o` show the new value from the edge that samples the write.
- R4: If `abort_i` is high at a clock edge, then after that edge `pin_oe_o` is all zero.
- R5: A direction write made while abort is active updates `dir_rd_o` at once. `pin_oe_o` stays all zero after every edge at which abort was sampled high. This includes a write sampled at the same edge as the rising abort.
- R6: If `abort_i` is low at a clock edge, then after that edge `pin_oe_o` equals the stored direction. This restores the drivers after an abort without any write, and it also covers a write sampled at the same edge as the abort release.
- R7: `pin_rd_o` shows the value `pin_i` had at the clock edge two edges earlier, through a two-stage synchronizer.
- R8: Writes to addresses 2 and 3 are ignored. Direction, output data and output enables are unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 direction, 1 output data, 2 and 3 unused |
| wr_data_i | input | N_PINS | Write data |
| abort_i | input | 1 | Safety abort; high forces every pin to input |
| pin_i | input | N_PINS | Asynchronous pin level samples |
| pin_oe_o | output | N_PINS | Per-pin output enable |
| pin_out_o | output | N_PINS | Per-pin drive level |
| dir_rd_o | output | N_PINS | Readback of the stored direction |
| dout_rd_o | output | N_PINS | Readback of the stored output data |
| pin_rd_o | output | N_PINS | Synchronized pin levels |

## Verification
The stimulus table runs the enable path under these patterns:
- a direction write with abort low;
- abort held with no write;
- direction and data writes inside an abort, which shows whether a write made during an abort leaks through to the enables;
- abort release with no write, which shows automatic restore apart from write-driven restore;
- a write and an abort edge sampled together, once at the rise and once at the fall, which exposes any one-cycle enable glitch or lost value at the boundary;
- an unmapped write placed between known states, which shows that decoding is exact.

Directed steps then check the reset state. They also check the two-edge synchronizer latency: the new pin level must be absent after one edge and present after two.

// File: rtl/gpio_safe_pkg.sv
package gpio_safe_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR  = 2'd0,
    SEL_DOUT = 2'd1,
    SEL_RSV2 = 2'd2,
    SEL_RSV3 = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_safe_pkg::*;
#(
  parameter int unsigned N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N_PINS-1:0] wr_data,
  output logic [N_PINS-1:0] dir_q,
  output logic [N_PINS-1:0] dout_q
);
  logic hit_dir, hit_dout;

  always_comb begin
    hit_dir  = wr_en && (reg_sel_e'(wr_addr) == SEL_DIR);
    hit_dout = wr_en && (reg_sel_e'(wr_addr) == SEL_DOUT);
  end

  // Direction bits are written even during an abort; the gate stage masks them.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
    end else begin
      if (hit_dir)  dir_q  <= wr_data;
      if (hit_dout) dout_q <= wr_data;
    end
  end

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_DIR) |=> dir_q == $past(wr_data));

  p_dout_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_DOUT) |=> dout_q == $past(wr_data));

  p_unmapped_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[1]) |=> ($stable(dir_q) && $stable(dout_q)));
endmodule

// File: rtl/gpio_abort_gate.sv
module gpio_abort_gate #(
  parameter int unsigned N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_in,
  input  logic [N_PINS-1:0] dir_q,
  output logic [N_PINS-1:0] oe
);
  logic abort_q;

  // Reset value 1 keeps every driver off until the first real sample.
  always_ff @(posedge clk) begin
    if (!rst_n) abort_q <= 1'b1;
    else        abort_q <= abort_in;
  end

  genvar g;
  generate
    for (g = 0; g < N_PINS; g++) begin : g_pin
      assign oe[g] = dir_q[g] & ~abort_q;
    end
  endgenerate

  p_abort_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort_in) |-> (oe == '0));

  p_oe_within_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oe & ~dir_q) == '0);
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned N_PINS      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_async,
  output logic [N_PINS-1:0] pin_sync
);
  logic [N_PINS-1:0] stage [SYNC_STAGES];

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage[s] <= '0;
          else        stage[s] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage[s] <= '0;
          else        stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign pin_sync = stage[SYNC_STAGES-1];

  // Count edges since reset so the latency check never reaches back into reset.
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  generate
    if (SYNC_STAGES == 2) begin : g_chk
      p_sync_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (pin_sync == $past(pin_async, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_safe_dir.sv
module gpio_safe_dir
  import gpio_safe_pkg::*;
#(
  parameter int unsigned N_PINS      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [N_PINS-1:0] wr_data_i,
  input  logic              abort_i,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic [N_PINS-1:0] pin_out_o,
  output logic [N_PINS-1:0] dir_rd_o,
  output logic [N_PINS-1:0] dout_rd_o,
  output logic [N_PINS-1:0] pin_rd_o
);
  logic [N_PINS-1:0] dir_q, dout_q;

  gpio_cfg_regs #(.N_PINS(N_PINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .dir_q   (dir_q),
    .dout_q  (dout_q)
  );

  gpio_abort_gate #(.N_PINS(N_PINS)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort_in (abort_i),
    .dir_q    (dir_q),
    .oe       (pin_oe_o)
  );

  gpio_in_sync #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (pin_i),
    .pin_sync  (pin_rd_o)
  );

  assign pin_out_o = dout_q;
  assign dir_rd_o  = dir_q;
  assign dout_rd_o = dout_q;

  p_release_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(abort_i) |-> (pin_oe_o == dir_rd_o));

  p_abort_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(abort_i) && $past(wr_en_i)) |-> (pin_oe_o == '0));
endmodule

// File: tb/sim_gpio_safe_dir.sv
module sim_gpio_safe_dir;
  localparam int unsigned N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [N-1:0]  wr_data = '0;
  logic          abort = 1'b0;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  oe, dout, dir_rd, dout_rd, pin_rd;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  gpio_safe_dir #(.N_PINS(N), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .abort_i(abort), .pin_i(pin_in),
    .pin_oe_o(oe), .pin_out_o(dout), .dir_rd_o(dir_rd),
    .dout_rd_o(dout_rd), .pin_rd_o(pin_rd)
  );

  typedef struct packed {
    logic         ab;
    logic         wr;
    logic [1:0]   ad;
    logic [15:0]  d;
    logic [15:0]  x_oe;
    logic [15:0]  x_out;
    logic [15:0]  x_dir;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b1, 2'd1, 16'hA5A5, 16'h0000, 16'hA5A5, 16'h0000}, // R3 data write
    '{1'b0, 1'b1, 2'd0, 16'h00FF, 16'h00FF, 16'hA5A5, 16'h00FF}, // R2 dir write
    '{1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000, 16'hA5A5, 16'h00FF}, // R4 abort
    '{1'b1, 1'b1, 2'd0, 16'hFFFF, 16'h0000, 16'hA5A5, 16'hFFFF}, // R5 dir write in abort
    '{1'b1, 1'b1, 2'd1, 16'h1234, 16'h0000, 16'h1234, 16'hFFFF}, // R5 data write in abort
    '{1'b0, 1'b0, 2'd0, 16'h0000, 16'hFFFF, 16'h1234, 16'hFFFF}, // R6 restore
    '{1'b0, 1'b1, 2'd3, 16'h0000, 16'hFFFF, 16'h1234, 16'hFFFF}, // R8 unmapped
    '{1'b0, 1'b1, 2'd0, 16'h0F0F, 16'h0F0F, 16'h1234, 16'h0F0F}, // R2
    '{1'b1, 1'b1, 2'd0, 16'hF0F0, 16'h0000, 16'h1234, 16'hF0F0}, // R5 write with abort rise
    '{1'b0, 1'b1, 2'd0, 16'h3C3C, 16'h3C3C, 16'h1234, 16'h3C3C}  // R6 write with release
  };

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 oe", oe, '0);
    check("R1 dir", dir_rd, '0);
    check("R1 dout", dout_rd, '0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      abort   = TBL[i].ab;
      wr_en   = TBL[i].wr;
      wr_addr = TBL[i].ad;
      wr_data = TBL[i].d;
      tick();
      check($sformatf("R2-R8 vec%0d oe", i), oe, TBL[i].x_oe);
      check($sformatf("R3 vec%0d out", i), dout, TBL[i].x_out);
      check($sformatf("R5 vec%0d dir", i), dir_rd, TBL[i].x_dir);
    end
    @(negedge clk);
    wr_en = 1'b0;
    abort = 1'b0;

    // R7: two-edge synchronizer latency
    @(negedge clk);
    pin_in = 16'hBEEF;
    tick();
    check("R7 after one edge", pin_rd, 16'h0000);
    tick();
    check("R7 after two edges", pin_rd, 16'hBEEF);

    // R8: other unmapped address keeps everything
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'hFFFF;
    tick();
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 dir", dir_rd, 16'h3C3C);
    check("R8 dout", dout_rd, 16'h1234);
    check("R8 oe", oe, 16'h3C3C);

    // R1: reset mid-run returns to all inputs
    @(negedge clk);
    rst_n = 1'b0;
    tick();
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 oe after reset", oe, '0);
    check("R1 dout after reset", dout, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule